// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block gathers interrupt requests from a row of device slices onto one shared request line toward a processor. Each slice holds a pending flag that its device sets with a one-cycle event pulse. While any flag is set, the shared request line is high.

When the processor answers with a single acknowledge, the acknowledge ripples through the slices in a fixed order, starting at slice 0. A slice with no pending request passes the acknowledge to the next slice in the same cycle. The first pending slice keeps the acknowledge and drives its own 8-bit identifying vector onto the shared vector bus. The processor uses that vector to pick a service routine.

When the processor drops the acknowledge, the winning slice clears its flag. Any other pending slices keep the request line high, so they are served in later acknowledges.

Top module: `vec_chain_intc`

## Requirements
- R1: After a synchronous reset, every pending flag is clear, `int_req` is 0, `vec_bus` is 0 and `vec_vld` is 0.
- R2: A high `dev_evt[i]` at a clock edge sets slice i's pending flag at that edge. The flag stays set until slice i is serviced.
- R3: `int_req` is high exactly when at least one slice is pending. It stays high until every pending slice has been serviced.
- R4: Slice 0 is nearest the processor and has top priority. Among pending slices, the one with the lowest index wins the acknowledge.
- R5: One clock edge after `int_ack` is seen high with a winner, `vec_bus` carries that winner's vector and `vec_vld` is 1. Slice i's vector is VEC_BASE + i*VEC_STRIDE (defaults 0x40 and 4, giving 0x40, 0x44, 0x48, 0x4C).
- R6: `ack_tail` is the acknowledge leaving the last slice. It equals `int_ack` when no slice is pending, and it is 0 whenever any slice is pending.
- R7: `vec_bus` reads 0 and `vec_vld` is 0 in the cycle after `int_ack` was low, and also when an acknowledge finds no pending slice.
- R8: At the first clock edge with `int_ack` low after an acknowledge, the winner's pending flag clears. Other slices stay pending and keep `int_req` high. The acknowledge must stay low for at least one cycle between services.
- R9: If the winner's event arrives on the same edge that would clear its flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_evt | input | N_SRC | Per-slice request event pulse |
| int_ack | input | 1 | Interrupt acknowledge from the processor |
| int_req | output | 1 | Shared interrupt request line |
| ack_tail | output | 1 | Acknowledge leaving the last slice of the chain |
| vec_bus | output | VEC_W | Vector of the winning slice, 0 when no slice drives it |
| vec_vld | output | 1 | A slice is driving `vec_bus` |

## Verification
On every cycle, the assertions check these relations:
- the request line follows incoming events;
- the acknowledge leaves the chain only when nothing is pending, and never while a request is pending;
- the vector bus is idle after a cycle without acknowledge;
- at most one slice holds the acknowledge at a time.

The directed scenarios are the only place that shows which vector value appears, and so whether chain order really sets priority. They also show that the winner alone is cleared while lower slices re-raise the line, and that a fresh event arriving with the clear keeps the slice pending.

// File: rtl/vec_chain_pkg.sv
package vec_chain_pkg;
  // Vector assigned to slice idx: base plus idx steps of stride.
  function automatic logic [7:0] slice_vec(input logic [7:0] base,
                                           input logic [7:0] stride,
                                           input int unsigned idx);
    logic [7:0] r;
    r = base + 8'(idx) * stride;
    return r;
  endfunction
endpackage

// File: rtl/vec_chain_slice.sv
module vec_chain_slice #(
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] MY_VEC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             int_ack,
  input  logic             ack_in,
  output logic             ack_out,
  output logic             pending,
  output logic             won,
  output logic [VEC_W-1:0] drv
);
  logic grant;
  logic clr;

  // Keep the acknowledge when pending, otherwise pass it on.
  assign grant   = ack_in & pending;
  assign ack_out = ack_in & ~pending;
  assign clr     = won & ~int_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      won     <= 1'b0;
      drv     <= '0;
    end else begin
      pending <= evt | (pending & ~clr);
      won     <= grant;
      drv     <= grant ? MY_VEC : '0;
    end
  end
endmodule

// File: rtl/vec_chain_or.sv
module vec_chain_or #(
  parameter int N_SRC = 4,
  parameter int VEC_W = 8
) (
  input  logic [N_SRC*VEC_W-1:0] drv_flat,
  output logic [VEC_W-1:0]       bus
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < N_SRC; i++) begin
      bus = bus | drv_flat[i*VEC_W +: VEC_W];
    end
  end
endmodule

// File: rtl/vec_chain_intc.sv
module vec_chain_intc #(
  parameter int N_SRC = 4,
  parameter int VEC_W = 8,
  parameter logic [7:0] VEC_BASE = 8'h40,
  parameter logic [7:0] VEC_STRIDE = 8'h04
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] dev_evt,
  input  logic             int_ack,
  output logic             int_req,
  output logic             ack_tail,
  output logic [VEC_W-1:0] vec_bus,
  output logic             vec_vld
);
  import vec_chain_pkg::*;

  localparam int FLAT_W = N_SRC * VEC_W;

  logic [N_SRC:0]    ack_link;
  logic [N_SRC-1:0]  pend_v;
  logic [N_SRC-1:0]  won_v;
  logic [FLAT_W-1:0] drv_flat;

  assign ack_link[0] = int_ack;

  for (genvar g = 0; g < N_SRC; g++) begin : g_slice
    vec_chain_slice #(
      .VEC_W (VEC_W),
      .MY_VEC(VEC_W'(slice_vec(VEC_BASE, VEC_STRIDE, g)))
    ) slice_i (
      .clk    (clk),
      .rst    (rst),
      .evt    (dev_evt[g]),
      .int_ack(int_ack),
      .ack_in (ack_link[g]),
      .ack_out(ack_link[g+1]),
      .pending(pend_v[g]),
      .won    (won_v[g]),
      .drv    (drv_flat[g*VEC_W +: VEC_W])
    );
  end

  vec_chain_or #(.N_SRC(N_SRC), .VEC_W(VEC_W)) or_i (
    .drv_flat(drv_flat),
    .bus     (vec_bus)
  );

  assign int_req  = |pend_v;
  assign vec_vld  = |won_v;
  assign ack_tail = ack_link[N_SRC];
endmodule

// File: rtl/vec_chain_intc_chk.sv
module vec_chain_intc_chk #(
  parameter int N_SRC = 4,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] dev_evt,
  input logic             int_ack,
  input logic             int_req,
  input logic             ack_tail,
  input logic [VEC_W-1:0] vec_bus,
  input logic             vec_vld,
  input logic [N_SRC-1:0] won_v
);
  // R2
  evt_raises_req_chk: assert property (@(posedge clk) disable iff (rst)
    (|dev_evt) |=> int_req);
  // R6
  ack_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    int_req |-> !ack_tail);
  // R6
  ack_passes_chk: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !int_req) |-> ack_tail);
  // R7
  bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !int_ack |=> (vec_bus == '0 && !vec_vld));
  // R4
  single_winner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(won_v));
endmodule

bind vec_chain_intc vec_chain_intc_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .dev_evt (dev_evt),
  .int_ack (int_ack),
  .int_req (int_req),
  .ack_tail(ack_tail),
  .vec_bus (vec_bus),
  .vec_vld (vec_vld),
  .won_v   (won_v)
);

// File: tb/vec_chain_intc_tb.sv
module vec_chain_intc_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] dev_evt = '0;
  logic       int_ack = 1'b0;
  logic       int_req, ack_tail, vec_vld;
  logic [7:0] vec_bus;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vec_chain_intc dut_i (
    .clk(clk), .rst(rst), .dev_evt(dev_evt), .int_ack(int_ack),
    .int_req(int_req), .ack_tail(ack_tail), .vec_bus(vec_bus), .vec_vld(vec_vld)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0; #1;
    chk("R1 int_req", 8'(int_req), 8'h0);
    chk("R1 vec_bus", vec_bus, 8'h00);
    chk("R1 vec_vld", 8'(vec_vld), 8'h0);
  endtask

  task automatic t_pass_through();
    int_ack = 1'b1; #1;
    chk("R6 tail follows ack with nothing pending", 8'(ack_tail), 8'h1);
    tick();
    chk("R7 no winner bus zero", vec_bus, 8'h00);
    chk("R7 no winner vld", 8'(vec_vld), 8'h0);
    int_ack = 1'b0; tick();
  endtask

  task automatic t_priority();
    dev_evt = 4'b1010; tick(); dev_evt = '0; #1;
    chk("R2 req after events", 8'(int_req), 8'h1);
    int_ack = 1'b1; #1;
    chk("R6 tail blocked", 8'(ack_tail), 8'h0);
    tick();
    chk("R4 R5 slice1 wins", vec_bus, 8'h44);
    chk("R5 vld", 8'(vec_vld), 8'h1);
    int_ack = 1'b0; tick();
    chk("R7 bus idle after drop", vec_bus, 8'h00);
    chk("R8 R3 req stays for slice3", 8'(int_req), 8'h1);
    int_ack = 1'b1; tick();
    chk("R8 slice3 next", vec_bus, 8'h4C);
    int_ack = 1'b0; tick();
    chk("R3 req low after all served", 8'(int_req), 8'h0);
  endtask

  task automatic t_top_slice();
    dev_evt = 4'b1001; tick(); dev_evt = '0;
    int_ack = 1'b1; tick();
    chk("R4 slice0 beats slice3", vec_bus, 8'h40);
    int_ack = 1'b0; tick();
    int_ack = 1'b1; tick();
    chk("R8 remaining slice3", vec_bus, 8'h4C);
    int_ack = 1'b0; tick();
    chk("R8 all clear", 8'(int_req), 8'h0);
  endtask

  task automatic t_hold_pending();
    dev_evt = 4'b0100; tick(); dev_evt = '0;
    chk("R2 pending held", 8'(int_req), 8'h1);
    tick();
    chk("R2 still pending without ack", 8'(int_req), 8'h1);
    int_ack = 1'b1; tick();
    chk("R5 slice2 vector", vec_bus, 8'h48);
    int_ack = 1'b0; dev_evt = 4'b0100; tick(); dev_evt = '0;
    chk("R9 re-event survives clear", 8'(int_req), 8'h1);
    int_ack = 1'b1; tick();
    chk("R9 slice2 again", vec_bus, 8'h48);
    int_ack = 1'b0; tick();
    chk("R8 cleared", 8'(int_req), 8'h0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_pass_through();
    t_priority();
    t_top_slice();
    t_hold_pending();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule